// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a hardware watchdog. Once armed, an internal counter starts at a programmed load value and counts down by one each clock. Software must send a one-cycle kick strobe to reload it. If the count runs down to a programmed threshold, a warning interrupt goes up. The warning gives the handler a last chance to kick. If the count then reaches zero with no kick, the block drives a fixed-length system reset pulse and records why it fired.

An optional window mode also catches code that is stuck in a tight loop which kicks too often. In this mode a kick that comes while the count is still above the window value is a fault, and the fault fires the reset at once. The block cannot be disarmed by software. After each reset pulse it reloads itself and keeps counting, so only the external reset returns it to the idle state.

Top module: `wdog_win`

## Requirements
- R1: After the clock edge that first samples `arm_i` high (call it edge 0), the count holds `load_i` (L). With no kick, `sys_rst_o` first reads high after edge L+1.
- R2: `warn_irq_o` rises after edge L-T+1, where T is `warn_thr_i`. That is the edge after the count equals T. It stays high until a valid kick is taken or until the reset pulse starts, and it reads low while `sys_rst_o` is high.
- R3: A valid kick reloads the count to L and clears `warn_irq_o` on the same edge. A kick taken at count zero is valid and prevents the reset.
- R4: `sys_rst_o` is high for exactly 4 cycles. After the pulse the count is reloaded and counting goes on, so the next timeout comes L+1 edges after the pulse ends. Kicks during the pulse are ignored.
- R5: With `win_en_i` high, a kick taken while the count is greater than `window_i` starts the reset pulse on that same edge.
- R6: With `win_en_i` high, a kick taken while the count is equal to or below `window_i` is valid. With `win_en_i` low, a kick at any count is valid.
- R7: `cause_o` reads 2'b01 after a timeout and 2'b10 after an early kick. It is never anything other than one of those two codes or 00. It keeps its value until the next fault overwrites it, and it returns to 00 only on `rst_n` low.
- R8: Before arming, neither output is active and the count follows `load_i`. After arming, lowering `arm_i` has no effect until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| arm_i | input | 1 | Arm request, sticky once seen |
| win_en_i | input | 1 | Window mode select |
| load_i | input | CW | Reload value of the count |
| window_i | input | CW | Highest count at which a kick is allowed in window mode |
| warn_thr_i | input | CW | Count at which the warning is raised |
| kick_i | input | 1 | One-cycle service strobe |
| warn_irq_o | output | 1 | Warning interrupt |
| sys_rst_o | output | 1 | System reset pulse |
| cause_o | output | 2 | Last fault cause: 01 timeout, 10 early kick |

## Verification
The bench places kicks exactly at the window boundary, which must be accepted, and one count above it, which must fire. A comparison that is off by one would either reset a well-behaved system or let an early kick through. It also kicks at count zero, which must save the system. A design that checks expiry before kicks would reset there. It kicks in the middle of the reset pulse; a design that honours that kick would shorten or restart the pulse. It drops the arm request and then times the timeout after the pulse. A disarmable design would go quiet, and a design that does not reload after the pulse would fire at the wrong time. The cause code is checked where a new fault overwrites it and where the external reset clears it.

// File: rtl/wdog_win.sv
module wdog_win #(
  parameter int CW    = 16,
  parameter int PULSE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          win_en_i,
  input  logic [CW-1:0] load_i,
  input  logic [CW-1:0] window_i,
  input  logic [CW-1:0] warn_thr_i,
  input  logic          kick_i,
  output logic          warn_irq_o,
  output logic          sys_rst_o,
  output logic [1:0]    cause_o
);
  localparam int PW = $clog2(PULSE + 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic          warn_q;
  logic [1:0]    cause_q;

  wire pulsing  = (pcnt != '0);
  wire live     = armed && !pulsing;
  wire early    = win_en_i && (cnt > window_i);
  wire kick_ok  = live && kick_i && !early;
  wire kick_bad = live && kick_i && early;
  wire expire   = live && !kick_i && (cnt == '0);
  wire fire     = kick_bad || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cnt     <= '0;
      pcnt    <= '0;
      warn_q  <= 1'b0;
      cause_q <= 2'b00;
    end else begin
      armed <= armed | arm_i;

      if (!armed || pulsing || kick_ok)
        cnt <= load_i;
      else if (!fire)
        cnt <= cnt - 1'b1;

      if (fire)
        pcnt <= PW'(PULSE);
      else if (pulsing)
        pcnt <= pcnt - 1'b1;

      if (fire || kick_ok)
        warn_q <= 1'b0;
      else if (live && cnt == warn_thr_i)
        warn_q <= 1'b1;

      if (kick_bad)
        cause_q <= 2'b10;
      else if (expire)
        cause_q <= 2'b01;
    end
  end

  assign warn_irq_o = warn_q;
  assign sys_rst_o  = pulsing;
  assign cause_o    = cause_q;
endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm_i,
  input logic       kick_i,
  input logic       warn_irq_o,
  input logic       sys_rst_o,
  input logic [1:0] cause_o
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= seen | arm_i;

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> sys_rst_o ##1 sys_rst_o ##1 sys_rst_o ##1 sys_rst_o ##1 !sys_rst_o);

  assert_warn_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_irq_o && !kick_i) |=> (warn_irq_o || sys_rst_o));

  assert_warn_off_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> !warn_irq_o);

  assert_cause_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_o));

  assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o != 2'b00) |=> (cause_o != 2'b00));

  assert_fault_logged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> (cause_o != 2'b00));

  assert_idle_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (!sys_rst_o && !warn_irq_o && cause_o == 2'b00));
endmodule

bind wdog_win wdog_win_chk u_chk (.*);

// File: tb/tb_wdog_win.sv
module tb_wdog_win;
  localparam int CW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, win = 1'b0, kick = 1'b0;
  logic [CW-1:0] load = '0, window = '0, thr = '0;
  logic warn, srst;
  logic [1:0] cause;
  int total = 0, bad = 0, k = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_win #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .win_en_i(win),
    .load_i(load), .window_i(window), .warn_thr_i(thr), .kick_i(kick),
    .warn_irq_o(warn), .sys_rst_o(srst), .cause_o(cause));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (k=%0d)", req, act, exp, k);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    k++;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    tick();
    kick = 1'b0;
  endtask

  task automatic ext_reset();
    rst_n = 1'b0; arm = 1'b0; kick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic arm_now();
    arm = 1'b1;
    @(negedge clk);
    k = 0;
    arm = 1'b0;
  endtask

  task automatic wait_rst(output int at);
    while (!srst && k < 500) tick();
    at = k;
  endtask

  task automatic test_idle();
    ext_reset();
    check(!warn && !srst && cause == 2'b00, "R7 reset state", {warn, srst, cause}, 0);
    load = 5; thr = 2; win = 1'b0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (warn || srst) begin
        check(0, "R8 unarmed stays quiet", {warn, srst}, 0);
        break;
      end
    end
    check(!warn && !srst, "R8 unarmed after 30 cycles", {warn, srst}, 0);
  endtask

  task automatic test_timeout();
    int at, width, wat;
    ext_reset();
    load = 20; thr = 5; win = 1'b0;
    arm_now();
    while (!warn && !srst && k < 100) tick();
    check(k == 16 && !srst, "R2 warn rise cycle", k, 16);
    wait_rst(at);
    check(at == 21, "R1 timeout cycle", at, 21);
    check(!warn, "R2 warn low in pulse", warn, 0);
    check(cause == 2'b01, "R7 timeout cause", cause, 1);
    width = 1;
    do_kick();
    while (srst && k < 200) begin
      width++;
      tick();
    end
    check(width == 4, "R4 pulse width with kick inside", width, 4);
    while (!warn && k < 200) tick();
    wat = k;
    check(wat == 41, "R8 warn after disarm attempt", wat, 41);
    wait_rst(at);
    check(at == 46, "R4 R8 repeat timeout cycle", at, 46);
  endtask

  task automatic test_kick();
    ext_reset();
    load = 20; thr = 5; win = 1'b0;
    arm_now();
    do_kick();
    check(!srst, "R6 kick at full count accepted", srst, 0);
    while (!warn && !srst && k < 100) tick();
    check(k == 17 && !srst, "R3 reload moves warn", k, 17);
    while (k < 21) tick();
    do_kick();
    check(!srst && !warn, "R3 kick at zero saves", {srst, warn}, 0);
    while (!warn && !srst && k < 100) tick();
    check(k == 38 && !srst, "R3 warn after zero kick", k, 38);
    do_kick();
    check(!warn && !srst, "R3 kick clears warn", warn, 0);
  endtask

  task automatic test_window();
    int at;
    ext_reset();
    load = 20; thr = 3; window = 8; win = 1'b1;
    arm_now();
    while (k < 4) tick();
    do_kick();
    check(srst == 1'b1, "R5 early kick fires", srst, 1);
    check(cause == 2'b10, "R7 early cause", cause, 2);
    while (srst && k < 100) tick();
    check(k == 9, "R4 pulse end after early kick", k, 9);
    while (k < 21) tick();
    do_kick();
    check(!srst, "R6 kick at window edge accepted", srst, 0);
    check(cause == 2'b10, "R7 cause held", cause, 2);
    while (k < 35) tick();
    do_kick();
    check(!srst, "R6 kick below window accepted", srst, 0);
    wait_rst(at);
    check(at == 57, "R1 timeout in window mode", at, 57);
    check(cause == 2'b01, "R7 cause overwritten", cause, 1);
    while (srst && k < 200) tick();
    while (k < 72) tick();
    do_kick();
    check(srst == 1'b1, "R5 kick one above window fires", srst, 1);
    check(cause == 2'b10, "R7 cause back to early", cause, 2);
    ext_reset();
    check(cause == 2'b00 && !srst && !warn, "R7 cleared by rst_n", cause, 0);
  endtask

  initial begin
    fork
      begin
        test_idle();
        test_timeout();
        test_kick();
        test_window();
      end
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule